// File: doc/BRIEF.md
# Dual-Group Peak/RMS Audio Limiter

This block limits the level of a small set of audio channels, one sample frame at a time. Two limiter engines run side by side. Each channel is assigned to the first engine, to the second, or to neither. An engine keeps one gain that it applies to every channel in its group. Each frame, the engine looks at the loudest magnitude in its group. If that level goes over an attack threshold, the gain is cut by an attack step. Otherwise the engine may restore gain. A release step is applied while a smoothed mean-square estimate of the limited level stays under a release threshold.

Each engine is driven by a small state machine that is advanced once per valid frame. It has four states:
- `ST_UNITY`: the gain is at 1.0 and nothing is happening.
- `ST_ATTACK`: the gain was cut on this frame.
- `ST_RELEASE`: the gain was raised on this frame.
- `ST_HOLD`: the gain is below 1.0 and was left unchanged.

The next state is chosen by priority. Attack comes first when the peak exceeds the attack threshold. Release comes next when the mean-square estimate is below the release threshold and the gain is below 1.0. Otherwise the engine goes to Unity when the gain is 1.0, and to Hold in every other case. Gain and estimate only move on the frame that makes the transition.

Thresholds are codes in 1 dB steps below full scale. Each engine can take them either from a packed 4-bit pair or from extended 7-bit fields. A per-engine mode bit chooses compression, which compares the raw input peak, or anti-clipping, which compares the peak after the current gain. Setting the top bit of either extended field forces anti-clipping.

Top module: `multichan_limiter`

## Requirements
- R1: After reset, `out_valid` and `out_data` are 0. Both gains are 1.0 (32768 in Q1.15) and both mean-square estimates are 0.
- R2: The channel map uses 2 bits per channel at bits [2c+1:2c]. Code 01 assigns the channel to engine 1 and code 10 to engine 2. Codes 00 and 11 leave the channel unmapped. An unmapped channel is output exactly as it came in, one frame later.
- R3: For each frame, an engine's peak is the largest absolute value over its mapped channels, with -32768 counting as 32768. An engine with no mapped channels has peak 0.
- R4: Attack fires when the compared level is strictly greater than the attack magnitude. The gain then drops by (A+1)*64, where A is rate bits [7:4]. The gain never goes below 1.
- R5: Release fires when attack does not, the estimate is strictly below the square of the release magnitude, and the gain is below 32768. The gain then rises by (R+1)*4, where R is rate bits [3:0], and is capped at 32768.
- R6: When attack and release conditions hold on the same frame, attack wins. The Unity state implies a gain of exactly 32768.
- R7: The limited level x is floor(peak*gain/32768). On each valid frame the estimate y becomes y + floor((x*x - y)/256). Both the release test and x use the gain from before that frame's update.
- R8: Code n maps to magnitude m(n), where m(0)=32767 and m(k+1)=floor(m(k)*58409/65536). The attack code is ext_att[6:0] when ext_att[7] is 1, and threshold bits [7:4] otherwise. The release code is ext_rel[6:0] when ext_rel[7] is 1, and threshold bits [3:0] otherwise.
- R9: With mode bit 1 (compression), the attack test uses the raw peak. With mode bit 0, or when ext_att[7] or ext_rel[7] is set, it uses the limited level x.
- R10: A channel's output is floor(sample*gain/32768), saturated to [-32768, 32767], using its engine's gain from before the update. It appears on the cycle after `in_valid`, with `out_valid` high for exactly that cycle. All channels of one engine use the same gain.
- R11: On cycles with `in_valid` low, gains, estimates and states do not change, and `out_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample frame is present |
| in_data | input | NCH*W | Signed samples, channel c at [c*W +: W] |
| chan_map | input | 2*NCH | Channel-to-engine assignment, 2 bits per channel |
| mode_drc | input | 2 | Per-engine mode, 1 = compression, 0 = anti-clipping |
| rate_cfg | input | 16 | Engine k at [8k +: 8]; attack step code [7:4], release step code [3:0] |
| thr_cfg | input | 16 | Engine k at [8k +: 8]; attack code [7:4], release code [3:0] |
| ext_att | input | 16 | Engine k at [8k +: 8]; select/force bit 7, code [6:0] |
| ext_rel | input | 16 | Engine k at [8k +: 8]; select/force bit 7, code [6:0] |
| out_valid | output | 1 | Output frame present |
| out_data | output | NCH*W | Limited, saturated samples |

## Verification
Attack and release can both be satisfied on the same frame. This happens when the estimate has sunk below the release threshold during quiet input and a loud peak then arrives while the gain is already reduced. The bench sets this up by cutting the gain with loud frames, letting it recover with quiet ones, and then injecting a single spike. The frame after the spike must show the gain lowered by exactly one attack step, and never raised. Anti-clipping and compression modes are also run on the same stimulus. There the raw and limited peaks fall on opposite sides of the attack threshold, so the two modes are expected to produce different gain histories.

// File: rtl/lim_pkg.sv
`timescale 1ns/1ps
package lim_pkg;

    typedef enum logic [1:0] {
        ST_UNITY   = 2'd0,
        ST_ATTACK  = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HOLD    = 2'd3
    } lim_state_e;

    localparam int unsigned DB_FACTOR_Q16 = 58409; // 10^(-1/20) in Q0.16

    // magnitude for a code of n dB below full scale
    function automatic logic [31:0] db_to_mag(input int unsigned code, input int unsigned fs);
        logic [31:0] m;
        m = fs;
        for (int i = 0; i < 128; i++) begin
            if (i < code) m = (m * DB_FACTOR_Q16) >> 16;
        end
        return m;
    endfunction

endpackage

// File: rtl/lim_peak.sv
`timescale 1ns/1ps
module lim_peak #(
    parameter int          NCH = 4,
    parameter int          W   = 16,
    parameter logic [1:0]  SEL = 2'b01
) (
    input  logic [NCH*W-1:0] samples,
    input  logic [2*NCH-1:0] chan_map,
    output logic [W:0]       peak
);
    logic signed [W:0] ext_s [NCH];
    logic        [W:0] mag_s [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_abs
        assign ext_s[c] = {samples[c*W+W-1], samples[c*W +: W]};
        assign mag_s[c] = ext_s[c][W] ? (W+1)'(-ext_s[c]) : ext_s[c];
    end

    always_comb begin
        peak = '0;
        for (int c = 0; c < NCH; c++) begin
            if (chan_map[2*c +: 2] == SEL && mag_s[c] > peak) peak = mag_s[c];
        end
    end
endmodule

// File: rtl/lim_core.sv
`timescale 1ns/1ps
module lim_core
    import lim_pkg::*;
#(
    parameter int W         = 16,
    parameter int FB        = 15,
    parameter int RMS_SHIFT = 8,
    parameter int NCODES    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W:0]        peak,
    input  logic [7:0]        rate,
    input  logic [7:0]        thr,
    input  logic [7:0]        xatt,
    input  logic [7:0]        xrel,
    input  logic              drc_mode,
    output logic [FB:0]       gain,
    output logic              attack_hit,
    output logic              release_ok,
    output lim_state_e        state
);
    localparam int          GW    = FB + 1;
    localparam int          RW    = 2 * W + 2;
    localparam logic [GW-1:0] UNITY = GW'(1) << FB;
    localparam int unsigned FS    = (1 << (W - 1)) - 1;

    logic [W-1:0] mag_tab [NCODES];
    for (genvar n = 0; n < NCODES; n++) begin : g_tab
        assign mag_tab[n] = W'(db_to_mag(n, FS));
    end

    logic [6:0]        acode, rcode;
    logic              anti;
    logic [W-1:0]      amag, rmag;
    logic [W+GW:0]     pk_prod;
    logic [W:0]        lim_pk, cmp_lvl;
    logic [RW-1:0]     sq, rel_sq;
    logic signed [RW:0] rms_q, diff, rms_nxt;
    logic [GW-1:0]     astep, rstep;
    lim_state_e        nxt;

    assign acode   = xatt[7] ? xatt[6:0] : {3'b000, thr[7:4]};
    assign rcode   = xrel[7] ? xrel[6:0] : {3'b000, thr[3:0]};
    assign anti    = !drc_mode || xatt[7] || xrel[7];
    assign amag    = mag_tab[acode];
    assign rmag    = mag_tab[rcode];
    assign pk_prod = peak * gain;
    assign lim_pk  = pk_prod[FB +: W+1];
    assign cmp_lvl = anti ? lim_pk : peak;
    assign sq      = lim_pk * lim_pk;
    assign rel_sq  = RW'(rmag * rmag);
    assign diff    = $signed({1'b0, sq}) - rms_q;
    assign rms_nxt = rms_q + (diff >>> RMS_SHIFT);
    assign astep   = GW'({2'b00, rate[7:4]} + 6'd1) << 6;
    assign rstep   = GW'({2'b00, rate[3:0]} + 6'd1) << 2;

    assign attack_hit = cmp_lvl > {1'b0, amag};
    assign release_ok = (rms_q < $signed({1'b0, rel_sq})) && (gain < UNITY);

    always_comb begin
        if (attack_hit)          nxt = ST_ATTACK;
        else if (release_ok)     nxt = ST_RELEASE;
        else if (gain == UNITY)  nxt = ST_UNITY;
        else                     nxt = ST_HOLD;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= ST_UNITY;
        else if (in_valid) state <= nxt;
    end

    // gain and estimate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain  <= UNITY;
            rms_q <= '0;
        end else if (in_valid) begin
            rms_q <= rms_nxt;
            unique case (nxt)
                ST_ATTACK:  gain <= (gain > astep) ? gain - astep : GW'(1);
                ST_RELEASE: gain <= ((UNITY - gain) > rstep) ? gain + rstep : UNITY;
                ST_UNITY,
                ST_HOLD:    gain <= gain;
            endcase
        end
    end
endmodule

// File: rtl/lim_scale.sv
`timescale 1ns/1ps
module lim_scale #(
    parameter int W  = 16,
    parameter int FB = 15
) (
    input  logic [W-1:0] sample,
    input  logic [FB:0]  gain,
    output logic [W-1:0] scaled
);
    localparam int PW = W + FB + 2;
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -PW'(1 << (W - 1));

    logic signed [PW-1:0] prod, sh;

    assign prod = $signed(sample) * $signed({1'b0, gain});
    assign sh   = prod >>> FB;

    always_comb begin
        if (sh > MAXV)      scaled = MAXV[W-1:0];
        else if (sh < MINV) scaled = MINV[W-1:0];
        else                scaled = sh[W-1:0];
    end
endmodule

// File: rtl/multichan_limiter.sv
`timescale 1ns/1ps
module multichan_limiter
    import lim_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 16,
    parameter int FB  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [NCH*W-1:0] in_data,
    input  logic [2*NCH-1:0] chan_map,
    input  logic [1:0]       mode_drc,
    input  logic [15:0]      rate_cfg,
    input  logic [15:0]      thr_cfg,
    input  logic [15:0]      ext_att,
    input  logic [15:0]      ext_rel,
    output logic             out_valid,
    output logic [NCH*W-1:0] out_data
);
    localparam int            NLIM  = 2;
    localparam int            GW    = FB + 1;
    localparam logic [GW-1:0] UNITY = GW'(1) << FB;

    logic [NLIM-1:0][W:0]    peak_v;
    logic [NLIM-1:0][GW-1:0] gain_v;
    logic [NLIM-1:0]         att_v, rel_v;
    lim_state_e [NLIM-1:0]   st_v;
    logic [NCH*W-1:0]        scaled;

    for (genvar l = 0; l < NLIM; l++) begin : g_lim
        lim_peak #(.NCH(NCH), .W(W), .SEL(2'(l + 1))) u_peak (
            .samples (in_data),
            .chan_map(chan_map),
            .peak    (peak_v[l])
        );
        lim_core #(.W(W), .FB(FB)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .peak      (peak_v[l]),
            .rate      (rate_cfg[8*l +: 8]),
            .thr       (thr_cfg[8*l +: 8]),
            .xatt      (ext_att[8*l +: 8]),
            .xrel      (ext_rel[8*l +: 8]),
            .drc_mode  (mode_drc[l]),
            .gain      (gain_v[l]),
            .attack_hit(att_v[l]),
            .release_ok(rel_v[l]),
            .state     (st_v[l])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [GW-1:0] gsel;
        assign gsel = (chan_map[2*c +: 2] == 2'b01) ? gain_v[0] :
                      (chan_map[2*c +: 2] == 2'b10) ? gain_v[1] : UNITY;
        lim_scale #(.W(W), .FB(FB)) u_scale (
            .sample(in_data[c*W +: W]),
            .gain  (gsel),
            .scaled(scaled[c*W +: W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= scaled;
        end
    end
endmodule

// File: rtl/lim_checker.sv
`timescale 1ns/1ps
module lim_checker
    import lim_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 16,
    parameter int FB  = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [NCH*W-1:0]      in_data,
    input logic [2*NCH-1:0]      chan_map,
    input logic                  out_valid,
    input logic [NCH*W-1:0]      out_data,
    input logic [1:0][FB:0]      gain_v,
    input logic [1:0]            att_v,
    input logic [1:0]            rel_v,
    input lim_state_e [1:0]      st_v
);
    localparam logic [FB:0] UNITY = (FB+1)'(1) << FB;

    p_valid_pipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    for (genvar l = 0; l < 2; l++) begin : g_l
        p_gain_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (gain_v[l] != '0) && (gain_v[l] <= UNITY));
        p_attack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && att_v[l] && gain_v[l] > 1) |=> gain_v[l] < $past(gain_v[l]));
        p_release_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && rel_v[l] && !att_v[l]) |=> gain_v[l] > $past(gain_v[l]));
        p_attack_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && att_v[l] && rel_v[l]) |=> st_v[l] == ST_ATTACK);
        p_unity_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_v[l] == ST_UNITY) |-> (gain_v[l] == UNITY));
        p_idle_gain_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(gain_v[l]) && $stable(st_v[l]));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_c
        p_unmapped_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (chan_map[2*c +: 2] == 2'b00 || chan_map[2*c +: 2] == 2'b11))
            |=> out_data[c*W +: W] == $past(in_data[c*W +: W]));
    end
endmodule

bind multichan_limiter lim_checker #(.NCH(NCH), .W(W), .FB(FB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .chan_map (chan_map),
    .out_valid(out_valid),
    .out_data (out_data),
    .gain_v   (gain_v),
    .att_v    (att_v),
    .rel_v    (rel_v),
    .st_v     (st_v)
);

// File: tb/sim_multichan_limiter.sv
`timescale 1ns/1ps
module sim_multichan_limiter;
    localparam int NCH = 4;
    localparam int W   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [NCH*W-1:0] in_data = '0;
    logic [2*NCH-1:0] cmap = '0;
    logic [1:0]       mode = 2'b11;
    logic [7:0]       rate [2];
    logic [7:0]       thr  [2];
    logic [7:0]       xatt [2];
    logic [7:0]       xrel [2];
    logic             out_valid;
    logic [NCH*W-1:0] out_data;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    longint m_gain [2];
    longint m_rms  [2];
    logic [NCH*W-1:0] last_out = '0;
    logic [31:0] lf = 32'h1357_9bdf;

    always #2.5 clk = ~clk;

    multichan_limiter #(.NCH(NCH), .W(W), .FB(15)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .chan_map(cmap), .mode_drc(mode),
        .rate_cfg({rate[1], rate[0]}), .thr_cfg({thr[1], thr[0]}),
        .ext_att({xatt[1], xatt[0]}), .ext_rel({xrel[1], xrel[0]}),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint mag_of(int code);
        longint m = 32767;
        for (int i = 0; i < code; i++) m = (m * 58409) >>> 16;
        return m;
    endfunction

    function automatic longint sx(logic [15:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [31:0] step_lf(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [NCH*W-1:0] act, input logic [NCH*W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic [NCH*W-1:0] smp, output logic [NCH*W-1:0] ex);
        longint gnow [2];
        for (int l = 0; l < 2; l++) begin
            longint pk = 0, x, cmp, ng, ac, rc;
            bit anti, att, rel;
            for (int c = 0; c < NCH; c++) begin
                longint a = sx(smp[c*W +: W]);
                if (a < 0) a = -a;
                if (cmap[2*c +: 2] == 2'(l + 1) && a > pk) pk = a;
            end
            ac   = xatt[l][7] ? longint'(xatt[l][6:0]) : longint'(thr[l][7:4]);
            rc   = xrel[l][7] ? longint'(xrel[l][6:0]) : longint'(thr[l][3:0]);
            anti = !mode[l] || xatt[l][7] || xrel[l][7];
            x    = (pk * m_gain[l]) >>> 15;
            cmp  = anti ? x : pk;
            att  = cmp > mag_of(int'(ac));
            rel  = (m_rms[l] < mag_of(int'(rc)) * mag_of(int'(rc))) && (m_gain[l] < 32768);
            ng   = m_gain[l];
            if (att) begin
                ng = ng - (longint'(rate[l][7:4]) + 1) * 64;
                if (ng < 1) ng = 1;
            end else if (rel) begin
                ng = ng + (longint'(rate[l][3:0]) + 1) * 4;
                if (ng > 32768) ng = 32768;
            end
            gnow[l]  = m_gain[l];
            m_rms[l] = m_rms[l] + ((x * x - m_rms[l]) >>> 8);
            m_gain[l] = ng;
        end
        for (int c = 0; c < NCH; c++) begin
            longint g = 32768, v;
            if (cmap[2*c +: 2] == 2'b01) g = gnow[0];
            if (cmap[2*c +: 2] == 2'b10) g = gnow[1];
            v = (sx(smp[c*W +: W]) * g) >>> 15;
            if (v > 32767) v = 32767;
            if (v < -32768) v = -32768;
            ex[c*W +: W] = 16'(v);
        end
    endtask

    task automatic apply(input logic [NCH*W-1:0] smp, input string tag);
        logic [NCH*W-1:0] ex;
        model_step(smp, ex);
        in_data  = smp;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1 && out_data === ex, tag, out_data, ex);
        last_out = ex;
    endtask

    task automatic idle(input string tag);
        lf = step_lf(lf);
        in_data  = {lf, ~lf};
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && out_data === last_out, tag, out_data, last_out);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int l = 0; l < 2; l++) begin m_gain[l] = 32768; m_rms[l] = 0; end
        last_out = '0;
    endtask

    function automatic logic [NCH*W-1:0] frame(int a, int b, int c, int d);
        return {16'(d), 16'(c), 16'(b), 16'(a)};
    endfunction

    task automatic cfg(input logic [7:0] r, input logic [7:0] t, input logic [1:0] md);
        for (int l = 0; l < 2; l++) begin
            rate[l] = r; thr[l] = t; xatt[l] = 8'h00; xrel[l] = 8'h00;
        end
        mode = md;
    endtask

    initial begin
        cfg(8'h33, 8'h60, 2'b11);
        do_reset();
        // R1: reset state
        check(out_valid === 1'b0 && out_data === '0, "R1 reset", out_data, '0);

        // R2: unmapped codes pass samples unchanged
        cmap = 8'b11_00_11_00;
        for (int v = -32768; v <= 32767; v += 257)
            apply(frame(v, 32767 - (v + 32768), -v - 1, v ^ 16'h5a5a), "R2 unmapped");
        apply(frame(-32768, 32767, -32768, 32767), "R2 extremes");

        // R3: peak across a group, negative full scale counts as largest
        do_reset();
        cmap = 8'hAA;
        for (int k = 0; k < 8; k++)
            apply(frame(1000 * k, -32768 + k, 20000, -3000), "R3 peak");

        // R4: attack step sweep over rate codes
        for (int a = 0; a < 16; a++) begin
            cfg({4'(a), 4'h3}, 8'h60, 2'b11);
            do_reset();
            cmap = 8'b00_00_01_01;
            for (int k = 0; k < 6; k++) apply(frame(32767, 100, 500, 500), "R4 attack");
        end

        // R5: release step sweep
        for (int r = 0; r < 16; r++) begin
            cfg({4'hF, 4'(r)}, 8'h60, 2'b11);
            do_reset();
            cmap = 8'b10_10_00_00;
            for (int k = 0; k < 4; k++)  apply(frame(0, 0, 30000, -30000), "R5 attack phase");
            for (int k = 0; k < 12; k++) apply(frame(0, 0, 8000, -7000), "R5 release");
        end

        // R6: attack and release on the same frame
        cfg(8'h40, 8'h60, 2'b11);
        do_reset();
        cmap = 8'b00_00_00_01;
        for (int k = 0; k < 3; k++) apply(frame(30000, 0, 0, 0), "R6 cut");
        for (int k = 0; k < 5; k++) apply(frame(100, 0, 0, 0), "R6 recover");
        apply(frame(30000, 0, 0, 0), "R6 both conditions");
        apply(frame(1000, 0, 0, 0), "R6 attack wins");

        // R9: compression versus anti-clipping on identical stimulus
        for (int md = 0; md < 4; md++) begin
            cfg(8'hF0, 8'h60, 2'(md));
            if (md == 3) xatt[0] = 8'h86;
            do_reset();
            cmap = 8'b00_10_00_01;
            for (int k = 0; k < 6; k++) apply(frame(32767, 0, -32768, 0), "R9 cut");
            for (int k = 0; k < 6; k++) apply(frame(20000, 0, -20000, 0), "R9 mode");
        end

        // R8: extended threshold codes, equal does not attack, one above does
        for (int code = 0; code < 128; code += 9) begin
            longint mg = mag_of(code);
            cfg(8'h70, 8'h00, 2'b11);
            xatt[0] = {1'b1, 7'(code)};
            xrel[1] = {1'b1, 7'(code)};
            do_reset();
            cmap = 8'b00_00_10_01;
            apply(frame(int'(mg), int'(mg), 0, 0), "R8 at threshold");
            apply(frame(int'(mg < 32767 ? mg + 1 : mg), 0, 0, 0), "R8 above threshold");
            apply(frame(4000, 4000, 0, 0), "R8 probe");
        end

        // R7/R10/R11: broad sweep over maps, rates, thresholds and modes with idle gaps
        for (int m = 0; m < 256; m++) begin
            lf = step_lf(lf);
            cfg(lf[7:0], lf[15:8], lf[17:16]);
            xatt[1] = {lf[18], lf[24:18]};
            xrel[0] = {lf[19], lf[30:24]};
            if (m % 32 == 0) do_reset();
            cmap = 8'(m);
            for (int k = 0; k < 8; k++) begin
                lf = step_lf(lf);
                apply({lf[15:0], lf[31:16], ~lf[15:0], lf[23:8]}, "R10 sweep");
                if (k == 3) idle("R11 idle hold");
            end
            apply(frame(1000, -1000, 2000, -2000), "R7 probe");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule